// File: doc/BRIEF.md
# Infrared Mark/Space Width Capture Controller

This block watches the output of an infrared receiver after carrier demodulation. It measures how long each mark (line low) and each space (line high) lasts, counted in sample periods. Each width is stored as one byte in a small bank of 32-bit data words. The first stored width is always a mark, and the entries then alternate between mark and space.

A message ends when a space reaches the largest byte value. Capture also stops when every byte slot is used. In either case an interrupt-pending flag is raised. Software then reads the data words, acknowledges the flag and writes a restart. The restart makes the next message begin again in the first slot.

Software uses a small register port to reach the block. Register writes take effect on the clock edge where the write strobe is sampled. A read returns its data two clock edges after the address is presented.

Top module: `ir_width_capture`

## Requirements
- R1: Capture runs only when both enable bits of the control register (offset 0x00) are 1: bit 0 (function on) and bit 13 (width detection on). While either bit is 0 the block counts nothing and stores nothing.
- R2: The sample period P is held in bits 20:8 of the period register (offset 0x04) and resets to 0xC00. The line is sampled once every P clock cycles, and a value of 0 acts as 1.
- R3: Slot n of the store is held in data word n/4 (byte address 0x80 + 4*word), at bits 8*(n mod 4)+7 down to 8*(n mod 4). With the default setting there are 17 words, which gives 68 slots.
- R4: The input passes through a two-flop synchronizer, and a low level is a mark. The first stored width is a mark, and the stored entries then alternate mark, space, mark, and so on. Each width is the number of samples that saw that level.
- R5: A width counter stops at 0xFF. A mark longer than that is stored as 0xFF when the line changes level. When a space reaches 0xFF, the value 0xFF is stored at once and the message ends.
- R6: Writing 1 to bit 0 of the restart register (offset 0x08) sends capture back to idle and empties the store. After a restart every data word reads zero, and the next width goes into word 0, byte 0.
- R7: The irq output is 1 exactly when the pending flag is 1 and bit 0 of the interrupt-enable register (offset 0x0C) is 1.
- R8: The pending flag is set when an end-of-message space is stored, or when the last free slot is written. It stays set until 1 is written to bit 0 of the acknowledge register (offset 0x10). If a set and an acknowledge fall in the same cycle, the set takes precedence.
- R9: While the line stays high before the first mark, no width is counted or stored.
- R10: Once a message has ended or the store is full, nothing more is stored until a restart is written.
- R11: Data words are read-only, and a write to them has no effect. Slots that have not been written read as zero. The control, period and interrupt-enable registers read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated receiver line; low means mark |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid two edges after the address |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with four data words (NUM_WORDS=4), which gives 16 slots. With that size a burst of short pulses fills the store after a few hundred cycles. This exercises the full-store interrupt, the freeze that follows it, and the masking of a partly written last word. The bench writes a period of 3 cycles. At that period a saturating 255-sample space takes under 800 cycles, so end-of-message, mark saturation and the case where the interrupt is masked and later enabled all fit in one short run. The period reset value is checked through readback.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_PERIOD = 8'h04;
  localparam logic [7:0] OFS_RESTRT = 8'h08;
  localparam logic [7:0] OFS_IEN    = 8'h0C;
  localparam logic [7:0] OFS_ACK    = 8'h10;
  localparam logic [7:0] OFS_DATA   = 8'h80;
  localparam int BIT_FUNC_EN  = 0;
  localparam int BIT_WIDTH_EN = 13;
  localparam int PER_LSB      = 8;

  typedef enum logic {CAP_IDLE, CAP_RUN} cap_state_t;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/ir_cap_sampler.sv
module ir_cap_sampler
  import ir_cap_pkg::*;
#(
  parameter int WB    = 8,
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  input  logic             line_s,
  input  logic             store_full,
  output logic             wr_en,
  output logic [WB-1:0]    wr_data,
  output logic             wr_mark,
  output logic             wr_end
);
  localparam logic [WB-1:0] W_MAX = '1;

  cap_state_t       st_q;
  logic [PER_W-1:0] pres_q;
  logic [PER_W-1:0] limit;
  logic [WB-1:0]    cnt_q, cnt_inc;
  logic             ph_q;
  logic             done_q;
  logic             tick, frozen, step, mark, same, chg, sat_end;

  assign limit   = (period == '0) ? '0 : period - 1'b1;
  assign tick    = (pres_q >= limit);
  assign frozen  = done_q | store_full;
  assign step    = active & ~restart & tick & ~frozen;
  assign mark    = ~line_s;
  assign cnt_inc = (cnt_q == W_MAX) ? W_MAX : cnt_q + 1'b1;
  assign same    = (mark == ph_q);
  assign chg     = ~same;
  assign sat_end = same & ~ph_q & (cnt_inc == W_MAX);

  assign wr_en   = step & (st_q == CAP_RUN) & (chg | sat_end);
  assign wr_end  = step & (st_q == CAP_RUN) & sat_end;
  assign wr_data = chg ? cnt_q : W_MAX;
  assign wr_mark = chg ? ph_q : 1'b0;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pres_q <= '0;
      st_q   <= CAP_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (active) begin
      pres_q <= tick ? '0 : pres_q + 1'b1;
      if (step) begin
        if (st_q == CAP_IDLE) begin
          if (mark) begin
            st_q  <= CAP_RUN;
            ph_q  <= 1'b1;
            cnt_q <= 1;
          end
        end else if (chg) begin
          ph_q  <= ~ph_q;
          cnt_q <= 1;
        end else if (sat_end) begin
          done_q <= 1'b1;
          cnt_q  <= W_MAX;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end else begin
      pres_q <= '0;
    end
  end

  assert_no_store_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !done_q && !store_full);
  assert_end_is_space_R5: assert property (@(posedge clk) disable iff (rst)
    wr_end |-> (!wr_mark && wr_data == W_MAX));
  assert_end_freezes_R10: assert property (@(posedge clk) disable iff (rst)
    wr_end |=> (done_q || $past(restart)));
  assert_idle_no_store_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAP_IDLE) |-> !wr_en);
endmodule

// File: rtl/ir_cap_store.sv
module ir_cap_store #(
  parameter int WORDS = 17,
  parameter int WB    = 8,
  parameter int LANES = 4,
  localparam int SLOTS = WORDS * LANES,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int AW    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                wr_en,
  input  logic [WB-1:0]       wr_data,
  input  logic [AW-1:0]       rd_word,
  output logic [LANES*WB-1:0] rd_data,
  output logic [CW-1:0]       count,
  output logic                full,
  output logic                last_write
);
  logic [LANES*WB-1:0] mem [WORDS];
  logic [CW-1:0]       cnt_q;
  logic [LANES*WB-1:0] rd_q;
  logic [LANES-1:0]    vld_q;
  logic [AW-1:0]       wr_word;
  logic [CW-1:0]       wr_lane;

  assign wr_word    = AW'(cnt_q / CW'(LANES));
  assign wr_lane    = cnt_q % CW'(LANES);
  assign full       = (cnt_q == CW'(SLOTS));
  assign last_write = wr_en & ~clear & (cnt_q == CW'(SLOTS - 1));
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en && !clear && !full)
      mem[wr_word][wr_lane*WB +: WB] <= wr_data;
    rd_q <= mem[rd_word];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (wr_en && !full) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      vld_q[l] <= (int'(rd_word) * LANES + l) < int'(cnt_q);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data[g*WB +: WB] = vld_q[g] ? rd_q[g*WB +: WB] : '0;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SLOTS));
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0);
  assert_no_write_full_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
endmodule

// File: rtl/ir_width_capture.sv
module ir_width_capture
  import ir_cap_pkg::*;
#(
  parameter int NUM_WORDS = 17,
  parameter int W_BITS    = 8,
  parameter int PER_W     = 13,
  parameter int PER_RESET = 3072
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int LANES = REG_W / W_BITS;
  localparam int SLOTS = NUM_WORDS * LANES;
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int AW    = $clog2(NUM_WORDS);

  logic             en_fn_q, en_wd_q, ien_q, pend_q;
  logic [PER_W-1:0] per_q;
  logic             line_s, restart, ack, active, set_evt;
  logic             s_wr, s_mark, s_end, full, last_w;
  logic [W_BITS-1:0] s_data;
  logic [CW-1:0]    count;
  logic [AW-1:0]    rd_word;
  logic [31:0]      st_rd;
  logic [7:0]       doff;
  logic             dhit, dsel_q;
  logic [31:0]      rv, rreg_q;

  assign restart = reg_wr && (reg_addr == OFS_RESTRT) && reg_wdata[0];
  assign ack     = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[0];
  assign active  = en_fn_q & en_wd_q;
  assign set_evt = (s_wr & s_end) | last_w;
  assign irq     = pend_q & ien_q;

  ir_cap_sync #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(ir_in), .dout(line_s));

  ir_cap_sampler #(.WB(W_BITS), .PER_W(PER_W)) u_samp (
    .clk(clk), .rst(rst), .active(active), .period(per_q),
    .restart(restart), .line_s(line_s), .store_full(full),
    .wr_en(s_wr), .wr_data(s_data), .wr_mark(s_mark), .wr_end(s_end));

  ir_cap_store #(.WORDS(NUM_WORDS), .WB(W_BITS), .LANES(LANES)) u_store (
    .clk(clk), .rst(rst), .clear(restart), .wr_en(s_wr), .wr_data(s_data),
    .rd_word(rd_word), .rd_data(st_rd), .count(count), .full(full),
    .last_write(last_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_fn_q <= 1'b0;
      en_wd_q <= 1'b0;
      ien_q   <= 1'b0;
      per_q   <= PER_W'(PER_RESET);
      pend_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL) begin
        en_fn_q <= reg_wdata[BIT_FUNC_EN];
        en_wd_q <= reg_wdata[BIT_WIDTH_EN];
      end
      if (reg_wr && reg_addr == OFS_PERIOD) per_q <= reg_wdata[PER_LSB +: PER_W];
      if (reg_wr && reg_addr == OFS_IEN) ien_q <= reg_wdata[0];
      if (set_evt) pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
    end
  end

  assign doff    = reg_addr - OFS_DATA;
  assign rd_word = AW'(doff >> 2);
  assign dhit    = (reg_addr >= OFS_DATA) && (int'(doff >> 2) < NUM_WORDS);

  always_comb begin
    rv = '0;
    case (reg_addr)
      OFS_CTRL: begin
        rv[BIT_FUNC_EN]  = en_fn_q;
        rv[BIT_WIDTH_EN] = en_wd_q;
      end
      OFS_PERIOD: rv[PER_LSB +: PER_W] = per_q;
      OFS_IEN:    rv[0] = ien_q;
      default:    rv = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsel_q    <= 1'b0;
      rreg_q    <= '0;
      reg_rdata <= '0;
    end else begin
      dsel_q    <= dhit;
      rreg_q    <= rv;
      reg_rdata <= dsel_q ? st_rd : rreg_q;
    end
  end

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    pend_q && !ack |=> pend_q);
  assert_pend_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(set_evt));
  assert_first_mark_R4: assert property (@(posedge clk) disable iff (rst)
    s_wr && count == '0 |-> s_mark);
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !active |-> !s_wr);
endmodule

// File: tb/ir_width_capture_tb_top.sv
module ir_width_capture_tb_top;
  localparam int NW    = 4;
  localparam int SLOTS = NW * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ir_in = 1'b1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_width_capture #(.NUM_WORDS(NW)) dut_i (
    .clk(clk), .rst(rst), .ir_in(ir_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // Behavioural reference model
  int m_fn, m_wd, m_per, m_ien, m_pend, q1, q2, pres, st, ph, cnt, nslot, done_m;
  int m_b[SLOTS];
  int evt, mk, tk, lim, nx, rs, ak;

  task automatic m_store(int v);
    if (nslot < SLOTS) begin
      m_b[nslot] = v;
      nslot++;
      if (nslot == SLOTS) evt = 1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_fn = 0; m_wd = 0; m_per = 3072; m_ien = 0; m_pend = 0;
      q1 = 1; q2 = 1; pres = 0; st = 0; ph = 0; cnt = 0; nslot = 0; done_m = 0;
    end else begin
      evt = 0;
      mk = (q2 == 0);
      q2 = q1; q1 = ir_in;
      rs = reg_wr && reg_addr == 8'h08 && reg_wdata[0];
      ak = reg_wr && reg_addr == 8'h10 && reg_wdata[0];
      if (rs) begin
        pres = 0; st = 0; ph = 0; cnt = 0; nslot = 0; done_m = 0;
      end else if (m_fn && m_wd) begin
        lim = (m_per == 0) ? 0 : m_per - 1;
        tk = (pres >= lim);
        pres = tk ? 0 : pres + 1;
        if (tk && !done_m && nslot < SLOTS) begin
          if (st == 0) begin
            if (mk) begin st = 1; ph = 1; cnt = 1; end
          end else if (mk != ph) begin
            m_store(cnt); ph = !ph; cnt = 1;
          end else begin
            nx = (cnt >= 255) ? 255 : cnt + 1;
            if (!ph && nx == 255) begin
              m_store(255); done_m = 1; evt = 1; cnt = 255;
            end else cnt = nx;
          end
        end
      end else pres = 0;
      if (evt) m_pend = 1;
      else if (ak) m_pend = 0;
      if (reg_wr && reg_addr == 8'h00) begin m_fn = reg_wdata[0]; m_wd = reg_wdata[13]; end
      if (reg_wr && reg_addr == 8'h04) m_per = int'(reg_wdata[20:8]);
      if (reg_wr && reg_addr == 8'h0C) m_ien = reg_wdata[0];
    end
  end

  // R7/R8: irq compared with the model every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== (m_pend && m_ien)) begin
        fails++;
        $display("FAIL R7/R8 irq actual=%0b expected=%0b at %0t", irq, (m_pend && m_ien), $time);
      end
    end
  end

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++)
      if (w * 4 + l < nslot) v[l*8 +: 8] = 8'(m_b[w*4+l]);
    return v;
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic hold(input logic lv, input int n);
    ir_in = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_words(input string tag);
    for (int w = 0; w < NW; w++) rd_chk(8'h80 + 8'(4 * w), exp_word(w), tag);
  endtask

  task automatic finish_up;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2, R11: reset values
    rd_chk(8'h04, 32'h000C_0000, "R2 period reset");
    rd_chk(8'h00, 32'h0, "R11 ctrl reset");
    chk_words("R11 empty after reset");
    wr_reg(8'h04, 32'd3 << 8);
    wr_reg(8'h0C, 32'h1);
    wr_reg(8'h00, 32'h2001);
    rd_chk(8'h00, 32'h2001, "R11 ctrl readback");
    rd_chk(8'h04, 32'h300, "R2 period readback");
    // R9: idle line stores nothing
    hold(1'b1, 60);
    chk_words("R9 idle no widths");
    // R3/R4/R5: message ending in saturated space
    hold(1'b0, 30); hold(1'b1, 21); hold(1'b0, 9);
    hold(1'b1, 820);
    checks++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R5 end irq actual=%0b expected=1", irq); end
    chk_words("R3 R4 R5 message words");
    // R10: frozen after end
    hold(1'b0, 20); hold(1'b1, 20);
    chk_words("R10 frozen after end");
    // R11: data writes ignored
    wr_reg(8'h80, 32'hDEAD_BEEF);
    chk_words("R11 data write ignored");
    wr_reg(8'h10, 32'h1);
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R8 ack irq actual=%0b expected=0", irq); end
    // R6: restart empties store
    wr_reg(8'h08, 32'h1);
    chk_words("R6 restart clears");
    // R8/R10: fill every slot with short pulses
    for (int i = 0; i < 12; i++) begin hold(1'b0, 6); hold(1'b1, 9); end
    hold(1'b1, 30);
    checks++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R8 full irq actual=%0b expected=1", irq); end
    chk_words("R10 R3 full store");
    wr_reg(8'h10, 32'h1);
    wr_reg(8'h08, 32'h1);
    // R1: width detection disabled
    wr_reg(8'h00, 32'h1);
    for (int i = 0; i < 4; i++) begin hold(1'b0, 12); hold(1'b1, 12); end
    chk_words("R1 disabled no capture");
    wr_reg(8'h00, 32'h2000);
    hold(1'b0, 12); hold(1'b1, 12);
    chk_words("R1 function bit off");
    // R5 mark saturation, R7 masked interrupt
    wr_reg(8'h0C, 32'h0);
    wr_reg(8'h00, 32'h2001);
    hold(1'b1, 10);
    hold(1'b0, 900);
    hold(1'b1, 820);
    chk_words("R5 mark saturation");
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R7 masked irq actual=%0b expected=0", irq); end
    wr_reg(8'h0C, 32'h1);
    checks++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R7 unmasked irq actual=%0b expected=1", irq); end
    wr_reg(8'h10, 32'h1);
    wr_reg(8'h08, 32'h1);
    hold(1'b1, 10);
    finish_up();
  end
endmodule